// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block sits on the device side of a raw 8-bit NAND flash bus. On every qualified bus write it classifies the byte as a command or an address byte. It keeps the current opcode and builds a multi-byte address, least significant byte first. It also works out the bus cycle on which each operation has to start. At that point it raises a one-cycle launch pulse. The opcode, the column and row split of the address, and the read column offset are held on outputs for the datapath downstream. The storage array, the page buffer and the read-data path all live outside this block.

Two parameters set the personality. `LARGE_PAGE` picks small-page behaviour (512-byte pages, one column byte) or large-page behaviour (2048-byte pages, two column bytes, column-change commands). `BIG_DENSITY` applies to large-page parts only. It picks the address-cycle count, which is four bytes for 1 Gbit or less and five bytes for 2 Gbit or more. The `busWrite` strobe marks the single clock cycle in which the bus byte is valid, with the write strobe already brought into the clock domain.

Top module: `flash_cmd_addr_decoder`

## Requirements
- R1: After reset `launch` is 0, `launchOp` is 0x00, `colAddr`, `rowAddr` and `readOffset` are 0, and `illegalCmd` is 0.
- R2: A byte is taken as a command only in a cycle with `busWrite` high, `ceN` low and `cle` high. It is taken as an address byte in a cycle with `busWrite` and `ale` high that is not a command cycle. Any other cycle changes no output.
- R3: Command 0x00 sets `readOffset` to 0. Command 0x01 sets it to 0x100. Command 0x50 sets it to the page size (512 for small-page, 2048 for large-page). All three leave `launchOp` at 0x00 and launch nothing.
- R4: Address byte number n (counting from 0 since the count was last reset) is stored at bits [8n+7:8n] of the address. Bytes after the `ADDR_BYTES`-th are dropped. `colAddr` is the low byte for small-page and the low two bytes for large-page. `rowAddr` is the rest, right-aligned.
- R5: With opcode 0x90, the launch comes from the first address byte.
- R6: With opcode 0x00 or 0x80, the launch comes from address byte 3 in small-page mode. In large-page mode it comes from byte 4 when `BIG_DENSITY`=0 and from byte 5 when `BIG_DENSITY`=1. No other address byte launches these opcodes.
- R7: Commands 0x70, 0x10, 0x60, 0xD0, 0x35, 0xE0 and 0xFF launch on the command byte itself, and `launchOp` shows that byte.
- R8: In large-page mode, command 0x30 arriving while the opcode is 0x00 is ignored: it gives no launch, no opcode change, no illegal flag and no address change.
- R9: In large-page mode, command 0x05 clears the column bytes and restarts the address byte count. It keeps the opcode and the row bytes, and launches nothing.
- R10: Every accepted command restarts the address byte count except 0xE0, after which the next address byte continues at the byte position where the count stood.
- R11: `launch` is high for exactly one cycle, the cycle after the triggering bus write. `launchOp` and the address outputs stay stable until a later bus write changes them.
- R12: Any other command byte sets `illegalCmd`, launches nothing and leaves the opcode and the address unchanged. `illegalCmd` then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | One-cycle qualifier: the bus byte is valid this cycle |
| ceN | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| ioIn | input | 8 | Bus byte |
| launch | output | 1 | One-cycle operation start pulse |
| launchOp | output | 8 | Current (launched) opcode |
| colAddr | output | 16 | Column part of the address, zero-extended |
| rowAddr | output | ADDR_BYTES*8-8 | Row part of the address, zero-extended |
| readOffset | output | 12 | Preset read column offset from the read alias |
| illegalCmd | output | 1 | Sticky unknown-command flag |

## Verification
The hardest state to reach is a column change in the middle of a large-page read. The count has to be restarted by 0x05 and then carried across 0xE0 without being reset. Only the next address byte shows this, by landing in a row lane rather than lane 0. The bench gets there with a full five-byte read address, then a column change, two new column bytes, the confirm command, and one more address byte. It checks the row output after each step. The three page-mode variants run side by side on one shared bus, so the same byte stream proves the launch lands on byte 3, 4 or 5 as required.

// File: rtl/fcad_pkg.sv
package fcad_pkg;

  localparam int ADDR_CNT_W = 3;
  localparam int OFFSET_W   = 12;
  localparam int COL_OUT_W  = 16;

  localparam logic [7:0] OP_READ         = 8'h00;
  localparam logic [7:0] OP_READ_HI      = 8'h01;
  localparam logic [7:0] OP_READ_SPARE   = 8'h50;
  localparam logic [7:0] OP_READ_CONFIRM = 8'h30;
  localparam logic [7:0] OP_READ_NOSER   = 8'h35;
  localparam logic [7:0] OP_COL_CHANGE   = 8'h05;
  localparam logic [7:0] OP_COL_CONFIRM  = 8'hE0;
  localparam logic [7:0] OP_READ_ID      = 8'h90;
  localparam logic [7:0] OP_RESET        = 8'hFF;
  localparam logic [7:0] OP_PROG_SETUP   = 8'h80;
  localparam logic [7:0] OP_PROG_GO      = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP  = 8'h60;
  localparam logic [7:0] OP_ERASE_GO     = 8'hD0;
  localparam logic [7:0] OP_STATUS       = 8'h70;

  typedef enum logic [1:0] {
    OFS_BASE  = 2'd0,
    OFS_UPPER = 2'd1,
    OFS_SPARE = 2'd2
  } ofsSel_e;

  // strobes from control to the address datapath
  typedef struct packed {
    logic    addrWrite;
    logic    countClear;
    logic    colClear;
    logic    offsetLoad;
    ofsSel_e offsetSel;
  } dpStrobe_t;

  // opcodes that start an operation on the command byte itself
  function automatic logic isImmediate(input logic [7:0] op);
    case (op)
      OP_STATUS, OP_PROG_GO, OP_ERASE_SETUP, OP_ERASE_GO,
      OP_READ_NOSER, OP_COL_CONFIRM, OP_RESET: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

  // opcodes accepted in every page mode
  function automatic logic isKnown(input logic [7:0] op);
    case (op)
      OP_READ, OP_READ_HI, OP_READ_SPARE, OP_READ_ID, OP_PROG_SETUP,
      OP_STATUS, OP_PROG_GO, OP_ERASE_SETUP, OP_ERASE_GO,
      OP_READ_NOSER, OP_COL_CONFIRM, OP_RESET: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fcad_ctrl.sv
module fcad_ctrl
  import fcad_pkg::*;
#(
  parameter bit LARGE_PAGE  = 1'b1,
  parameter bit BIG_DENSITY = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busWrite,
  input  logic                  ceN,
  input  logic                  cle,
  input  logic                  ale,
  input  logic [7:0]            ioIn,
  input  logic [ADDR_CNT_W-1:0] addrCount,
  output dpStrobe_t             strobe,
  output logic                  launch,
  output logic [7:0]            opcode,
  output logic                  illegalCmd
);

  localparam int LAUNCH_AT = LARGE_PAGE ? (BIG_DENSITY ? 5 : 4) : 3;
  localparam logic [ADDR_CNT_W-1:0] LAUNCH_CNT = ADDR_CNT_W'(LAUNCH_AT);
  localparam logic [ADDR_CNT_W-1:0] CNT_ONE    = ADDR_CNT_W'(1);
  localparam logic [ADDR_CNT_W-1:0] CNT_MAX    = '1;

  logic                  cmdCycle;
  logic                  adrCycle;
  logic [ADDR_CNT_W-1:0] nextCount;
  logic [7:0]            opNext;
  logic                  launchNext;
  logic                  illegalSet;

  assign cmdCycle  = busWrite && !ceN && cle;
  assign adrCycle  = busWrite && ale && !cmdCycle;
  assign nextCount = (addrCount == CNT_MAX) ? CNT_MAX : addrCount + 1'b1;

  always_comb begin
    strobe           = '0;
    strobe.offsetSel = OFS_BASE;
    opNext           = opcode;
    launchNext       = 1'b0;
    illegalSet       = 1'b0;
    if (cmdCycle) begin
      if (LARGE_PAGE && opcode == OP_READ && ioIn == OP_READ_CONFIRM) begin
        // confirm after read setup: no effect
      end else if (LARGE_PAGE && ioIn == OP_COL_CHANGE) begin
        strobe.colClear   = 1'b1;
        strobe.countClear = 1'b1;
      end else if (isKnown(ioIn)) begin
        strobe.countClear = (ioIn != OP_COL_CONFIRM);
        launchNext        = isImmediate(ioIn);
        case (ioIn)
          OP_READ: begin
            strobe.offsetLoad = 1'b1;
            strobe.offsetSel  = OFS_BASE;
            opNext            = OP_READ;
          end
          OP_READ_HI: begin
            strobe.offsetLoad = 1'b1;
            strobe.offsetSel  = OFS_UPPER;
            opNext            = OP_READ;
          end
          OP_READ_SPARE: begin
            strobe.offsetLoad = 1'b1;
            strobe.offsetSel  = OFS_SPARE;
            opNext            = OP_READ;
          end
          default: opNext = ioIn;
        endcase
      end else begin
        illegalSet = 1'b1;
      end
    end else if (adrCycle) begin
      strobe.addrWrite = 1'b1;
      if (opcode == OP_READ_ID && nextCount == CNT_ONE) begin
        launchNext = 1'b1;
      end
      if ((opcode == OP_READ || opcode == OP_PROG_SETUP) && nextCount == LAUNCH_CNT) begin
        launchNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode     <= OP_READ;
      launch     <= 1'b0;
      illegalCmd <= 1'b0;
    end else begin
      opcode     <= opNext;
      launch     <= launchNext;
      illegalCmd <= illegalCmd | illegalSet;
    end
  end

  // R11: a launch always follows a bus write
  p_launch_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(busWrite));

  // R12: the illegal flag never drops outside reset
  p_illegal_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegalCmd |=> illegalCmd);

  // R5: an ID launch coincides with exactly one address byte held
  p_id_first_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && opcode == OP_READ_ID) |-> addrCount == CNT_ONE);

  // R6: read/program launch only at the mode's address-cycle count
  p_rw_launch_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && (opcode == OP_READ || opcode == OP_PROG_SETUP)) |-> addrCount == LAUNCH_CNT);

  // R10: the column confirm command keeps the byte count
  p_confirm_keeps_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && opcode == OP_COL_CONFIRM) |-> $stable(addrCount));

endmodule

// File: rtl/fcad_addr.sv
module fcad_addr
  import fcad_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter int ADDR_BYTES = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              ioIn,
  input  dpStrobe_t               strobe,
  output logic [ADDR_CNT_W-1:0]   addrCount,
  output logic [COL_OUT_W-1:0]    colAddr,
  output logic [ADDR_BYTES*8-9:0] rowAddr,
  output logic [OFFSET_W-1:0]     readOffset
);

  localparam int COL_BYTES  = LARGE_PAGE ? 2 : 1;
  localparam int COL_W      = COL_BYTES * 8;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int ROW_OUT_W  = ADDR_W - 8;
  localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : 512;
  localparam logic [ADDR_CNT_W-1:0] CNT_MAX = '1;

  logic [ADDR_W-1:0] addrFlat;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
    localparam logic [ADDR_CNT_W-1:0] LANE = ADDR_CNT_W'(b);
    localparam bit IS_COL = (b < COL_BYTES);
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        laneQ <= '0;
      end else if (IS_COL && strobe.colClear) begin
        laneQ <= '0;
      end else if (strobe.addrWrite && addrCount == LANE) begin
        laneQ <= ioIn;
      end
    end
    assign addrFlat[b*8 +: 8] = laneQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrCount <= '0;
    end else if (strobe.countClear) begin
      addrCount <= '0;
    end else if (strobe.addrWrite && addrCount != CNT_MAX) begin
      addrCount <= addrCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readOffset <= '0;
    end else if (strobe.offsetLoad) begin
      case (strobe.offsetSel)
        OFS_UPPER: readOffset <= OFFSET_W'(256);
        OFS_SPARE: readOffset <= OFFSET_W'(PAGE_BYTES);
        default:   readOffset <= '0;
      endcase
    end
  end

  assign colAddr = COL_OUT_W'(addrFlat[COL_W-1:0]);
  assign rowAddr = ROW_OUT_W'(addrFlat[ADDR_W-1:COL_W]);

  // R4: each accepted address byte advances the count by one
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.addrWrite && !strobe.countClear && addrCount != CNT_MAX)
      |=> addrCount == $past(addrCount) + 1'b1);

  // R10: a count restart is seen on the next cycle
  p_count_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.countClear |=> addrCount == '0);

endmodule

// File: rtl/flash_cmd_addr_decoder.sv
module flash_cmd_addr_decoder
  import fcad_pkg::*;
#(
  parameter bit LARGE_PAGE  = 1'b1,
  parameter bit BIG_DENSITY = 1'b0,
  parameter int ADDR_BYTES  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busWrite,
  input  logic                    ceN,
  input  logic                    cle,
  input  logic                    ale,
  input  logic [7:0]              ioIn,
  output logic                    launch,
  output logic [7:0]              launchOp,
  output logic [COL_OUT_W-1:0]    colAddr,
  output logic [ADDR_BYTES*8-9:0] rowAddr,
  output logic [OFFSET_W-1:0]     readOffset,
  output logic                    illegalCmd
);

  dpStrobe_t             strobe;
  logic [ADDR_CNT_W-1:0] addrCount;

  fcad_ctrl #(
    .LARGE_PAGE (LARGE_PAGE),
    .BIG_DENSITY(BIG_DENSITY)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busWrite  (busWrite),
    .ceN       (ceN),
    .cle       (cle),
    .ale       (ale),
    .ioIn      (ioIn),
    .addrCount (addrCount),
    .strobe    (strobe),
    .launch    (launch),
    .opcode    (launchOp),
    .illegalCmd(illegalCmd)
  );

  fcad_addr #(
    .LARGE_PAGE(LARGE_PAGE),
    .ADDR_BYTES(ADDR_BYTES)
  ) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ioIn      (ioIn),
    .strobe    (strobe),
    .addrCount (addrCount),
    .colAddr   (colAddr),
    .rowAddr   (rowAddr),
    .readOffset(readOffset)
  );

endmodule

// File: tb/test_flash_cmd_addr_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_addr_decoder;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, busWrite, ceN, cle, ale;
  logic [7:0] ioIn;

  logic [2:0]        launchV, illV;
  logic [2:0][7:0]   opV;
  logic [2:0][15:0]  colV;
  logic [2:0][31:0]  rowV;
  logic [2:0][11:0]  offV;

  int errors = 0;
  int checks = 0;

  // index 0: small page, 1: large page <=1 Gbit, 2: large page >=2 Gbit
  flash_cmd_addr_decoder #(.LARGE_PAGE(1'b0), .BIG_DENSITY(1'b0)) i_flash_cmd_addr_decoder_sp (
    .clk(clk), .rst_n(rst_n), .busWrite(busWrite), .ceN(ceN), .cle(cle), .ale(ale), .ioIn(ioIn),
    .launch(launchV[0]), .launchOp(opV[0]), .colAddr(colV[0]), .rowAddr(rowV[0]),
    .readOffset(offV[0]), .illegalCmd(illV[0]));

  flash_cmd_addr_decoder #(.LARGE_PAGE(1'b1), .BIG_DENSITY(1'b0)) i_flash_cmd_addr_decoder (
    .clk(clk), .rst_n(rst_n), .busWrite(busWrite), .ceN(ceN), .cle(cle), .ale(ale), .ioIn(ioIn),
    .launch(launchV[1]), .launchOp(opV[1]), .colAddr(colV[1]), .rowAddr(rowV[1]),
    .readOffset(offV[1]), .illegalCmd(illV[1]));

  flash_cmd_addr_decoder #(.LARGE_PAGE(1'b1), .BIG_DENSITY(1'b1)) i_flash_cmd_addr_decoder_big (
    .clk(clk), .rst_n(rst_n), .busWrite(busWrite), .ceN(ceN), .cle(cle), .ale(ale), .ioIn(ioIn),
    .launch(launchV[2]), .launchOp(opV[2]), .colAddr(colV[2]), .rowAddr(rowV[2]),
    .readOffset(offV[2]), .illegalCmd(illV[2]));

  function automatic int launchAt(input int d);
    return (d == 0) ? 3 : ((d == 1) ? 4 : 5);
  endfunction

  function automatic string dutName(input int d);
    return (d == 0) ? "small" : ((d == 1) ? "mid" : "big");
  endfunction

  task automatic chk(input string req, input int d, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s: actual=%0h expected=%0h", req, dutName(d), what, act, exp);
    end
  endtask

  // one qualified bus write; returns at the negedge after the capturing edge
  task automatic busCycle(input logic c, input logic l, input logic a, input logic [7:0] v);
    @(negedge clk);
    ceN = c; cle = l; ale = a; ioIn = v; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; cle = 1'b0; ale = 1'b0; ceN = 1'b1;
  endtask

  task automatic cmd(input logic [7:0] v);
    busCycle(1'b0, 1'b1, 1'b0, v);
  endtask

  task automatic adr(input logic [7:0] v);
    busCycle(1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; busWrite = 1'b0; ceN = 1'b1; cle = 1'b0; ale = 1'b0; ioIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R1", d, "launch", launchV[d], 0);
      chk("R1", d, "op", opV[d], 8'h00);
      chk("R1", d, "col", colV[d], 0);
      chk("R1", d, "row", rowV[d], 0);
      chk("R1", d, "offset", offV[d], 0);
      chk("R1", d, "illegal", illV[d], 0);
    end
  endtask

  task automatic t_status();
    cmd(8'h70);
    for (int d = 0; d < 3; d++) begin
      chk("R7", d, "status launch", launchV[d], 1);
      chk("R7", d, "status op", opV[d], 8'h70);
    end
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R11", d, "pulse ends", launchV[d], 0);
      chk("R11", d, "op held", opV[d], 8'h70);
    end
  endtask

  task automatic t_qualify();
    busCycle(1'b1, 1'b1, 1'b0, 8'h60);
    for (int d = 0; d < 3; d++) begin
      chk("R2", d, "ce high launch", launchV[d], 0);
      chk("R2", d, "ce high op", opV[d], 8'h70);
    end
    @(negedge clk);
    ceN = 1'b0; cle = 1'b1; ioIn = 8'hFF; busWrite = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R2", d, "no busWrite launch", launchV[d], 0);
      chk("R2", d, "no busWrite op", opV[d], 8'h70);
    end
    ceN = 1'b1; cle = 1'b0;
  endtask

  task automatic t_read();
    logic [7:0] bytes [5] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
    cmd(8'h00);
    for (int d = 0; d < 3; d++) chk("R6", d, "read setup launch", launchV[d], 0);
    for (int i = 0; i < 5; i++) begin
      adr(bytes[i]);
      for (int d = 0; d < 3; d++) begin
        chk("R6", d, $sformatf("read byte %0d launch", i + 1), launchV[d], (i + 1 == launchAt(d)));
        if (i + 1 == launchAt(d)) chk("R6", d, "read op", opV[d], 8'h00);
      end
    end
    chk("R4", 0, "col", colV[0], 16'h0012);
    chk("R4", 0, "row", rowV[0], 32'h9A785634);
    for (int d = 1; d < 3; d++) begin
      chk("R4", d, "col", colV[d], 16'h3412);
      chk("R4", d, "row", rowV[d], 32'h009A7856);
    end
    adr(8'hEE);
    chk("R4", 0, "extra byte row", rowV[0], 32'h9A785634);
    for (int d = 1; d < 3; d++) chk("R4", d, "extra byte row", rowV[d], 32'h009A7856);
    for (int d = 0; d < 3; d++) chk("R6", d, "extra byte launch", launchV[d], 0);
  endtask

  task automatic t_alias();
    cmd(8'h01);
    for (int d = 0; d < 3; d++) begin
      chk("R3", d, "0x01 offset", offV[d], 12'h100);
      chk("R3", d, "0x01 op", opV[d], 8'h00);
      chk("R3", d, "0x01 launch", launchV[d], 0);
    end
    cmd(8'h50);
    chk("R3", 0, "0x50 offset", offV[0], 12'd512);
    for (int d = 1; d < 3; d++) chk("R3", d, "0x50 offset", offV[d], 12'd2048);
    for (int d = 0; d < 3; d++) chk("R3", d, "0x50 op", opV[d], 8'h00);
    cmd(8'h00);
    for (int d = 0; d < 3; d++) chk("R3", d, "0x00 offset", offV[d], 12'h000);
  endtask

  task automatic t_id();
    cmd(8'h90);
    for (int d = 0; d < 3; d++) chk("R5", d, "id cmd launch", launchV[d], 0);
    adr(8'h00);
    for (int d = 0; d < 3; d++) begin
      chk("R5", d, "id launch", launchV[d], 1);
      chk("R5", d, "id op", opV[d], 8'h90);
    end
    adr(8'h00);
    for (int d = 0; d < 3; d++) chk("R5", d, "id second byte", launchV[d], 0);
    cmd(8'h90);
    adr(8'hAB);
    for (int d = 0; d < 3; d++) chk("R10", d, "count reset relaunch", launchV[d], 1);
  endtask

  task automatic t_program();
    cmd(8'h80);
    for (int d = 0; d < 3; d++) chk("R6", d, "prog setup launch", launchV[d], 0);
    for (int i = 0; i < 5; i++) begin
      adr(8'(8'hA0 + i));
      for (int d = 0; d < 3; d++) begin
        chk("R6", d, $sformatf("prog byte %0d launch", i + 1), launchV[d], (i + 1 == launchAt(d)));
        if (i + 1 == launchAt(d)) chk("R6", d, "prog op", opV[d], 8'h80);
      end
    end
    chk("R4", 0, "prog col", colV[0], 16'h00A0);
    chk("R4", 1, "prog col", colV[1], 16'hA1A0);
    cmd(8'h10);
    for (int d = 0; d < 3; d++) begin
      chk("R7", d, "prog go launch", launchV[d], 1);
      chk("R7", d, "prog go op", opV[d], 8'h10);
    end
  endtask

  task automatic t_erase();
    cmd(8'h60);
    for (int d = 0; d < 3; d++) chk("R7", d, "erase setup launch", launchV[d], 1);
    for (int i = 0; i < 3; i++) begin
      adr(8'(8'h40 + i));
      for (int d = 0; d < 3; d++) chk("R7", d, "erase addr no launch", launchV[d], 0);
    end
    cmd(8'hD0);
    for (int d = 0; d < 3; d++) begin
      chk("R7", d, "erase go launch", launchV[d], 1);
      chk("R7", d, "erase go op", opV[d], 8'hD0);
    end
    cmd(8'hFF);
    for (int d = 0; d < 3; d++) chk("R7", d, "reset cmd op", opV[d], 8'hFF);
    cmd(8'h35);
    for (int d = 0; d < 3; d++) begin
      chk("R7", d, "no-serial read launch", launchV[d], 1);
      chk("R7", d, "no-serial read op", opV[d], 8'h35);
    end
  endtask

  task automatic t_confirm();
    cmd(8'h00);
    for (int i = 0; i < 5; i++) adr(8'(8'h11 * (i + 1)));
    cmd(8'h30);
    for (int d = 1; d < 3; d++) begin
      chk("R8", d, "0x30 launch", launchV[d], 0);
      chk("R8", d, "0x30 op", opV[d], 8'h00);
      chk("R8", d, "0x30 illegal", illV[d], 0);
      chk("R8", d, "0x30 col", colV[d], 16'h2211);
    end
    chk("R12", 0, "0x30 small illegal", illV[0], 1);
    chk("R12", 0, "0x30 small launch", launchV[0], 0);
    chk("R12", 0, "0x30 small op", opV[0], 8'h00);
  endtask

  task automatic t_colchange();
    cmd(8'h05);
    for (int d = 1; d < 3; d++) begin
      chk("R9", d, "col change launch", launchV[d], 0);
      chk("R9", d, "col change op", opV[d], 8'h00);
      chk("R9", d, "col cleared", colV[d], 16'h0000);
      chk("R9", d, "row kept", rowV[d], 32'h00554433);
    end
    adr(8'hAA);
    adr(8'hBB);
    for (int d = 1; d < 3; d++) begin
      chk("R9", d, "new col", colV[d], 16'hBBAA);
      chk("R9", d, "new col no launch", launchV[d], 0);
    end
    cmd(8'hE0);
    for (int d = 1; d < 3; d++) begin
      chk("R7", d, "confirm launch", launchV[d], 1);
      chk("R7", d, "confirm op", opV[d], 8'hE0);
    end
    adr(8'hCC);
    for (int d = 1; d < 3; d++) chk("R10", d, "count kept by 0xE0", rowV[d], 32'h005544CC);
  endtask

  task automatic t_unknown();
    cmd(8'hAB);
    for (int d = 0; d < 3; d++) begin
      chk("R12", d, "unknown launch", launchV[d], 0);
      chk("R12", d, "unknown op", opV[d], 8'hE0);
      chk("R12", d, "unknown flag", illV[d], 1);
    end
    cmd(8'h70);
    for (int d = 0; d < 3; d++) begin
      chk("R12", d, "flag sticky", illV[d], 1);
      chk("R7", d, "status after illegal", launchV[d], 1);
    end
  endtask

  initial begin
    t_reset();
    t_status();
    t_qualify();
    t_read();
    t_alias();
    t_id();
    t_program();
    t_erase();
    t_confirm();
    t_colchange();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R11: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule